// File: doc/BRIEF.md
# Standby Power-State Sequencer

This block sequences the clocks and the internal reset of a small processor core through five power states: reset, oscillator settle wait, RUN, SLEEP and STOP. Software asks for a low-power state by writing a sleep or a stop bit into a standby control register. The block then gates the CPU clock, the peripheral clocks and the oscillator enable to suit the new state.

SLEEP is left on any pending interrupt. STOP is left only on an external interrupt. Because the oscillator was shut down in STOP, it must settle again before the core runs, so STOP exit passes through a timed wait held by an internal down-counter. An external reset can cut into any low-power state or the wait.

A build option selects whether the device has a power-on reset source. With it, the first state after power-up is the settle wait, and reset is held until the counter finishes. Without it, the first state is reset, and the external reset pin must be held until the oscillator is stable.

Top module: `pwr_standby_ctl`

## Requirements
- R1: With HAS_POR=1, after `por_n` rises the block is in state 1 (settle wait) with `int_rst`=1, both clock enables 0 and `osc_en`=1. It enters RUN exactly STAB_CYCLES+1 clock edges later.
- R2: With HAS_POR=0, after `por_n` rises the block is in state 0 (reset) and stays there while `ext_rst`=1. It is in RUN one edge after `ext_rst` falls.
- R3: In RUN, a write with `wr_slp`=1, `wr_stp`=0 and no pending interrupt gives state 3 (SLEEP) and `stbc_slp`=1 after the next edge.
- R4: In RUN, a write with `wr_stp`=1 gives state 4 (STOP) whatever `wr_slp` holds. Afterwards `stbc_stp`=1 and `stbc_slp`=0.
- R5: A standby write made while `irq_any`=1 is ignored: the state stays RUN and both register bits stay 0.
- R6: In SLEEP, `irq_any`=1 returns the block to RUN on the next edge, and `ext_rst`=1 sends it to reset.
- R7: In STOP, `irq_any` alone has no effect. `ext_irq`=1 moves the block to state 1, and `ext_rst`=1 sends it to reset.
- R8: The settle wait after STOP lasts exactly STAB_CYCLES+1 cycles before RUN, with the counter reloaded on every entry, and `int_rst`=0 throughout.
- R9: `ext_rst`=1 during the settle wait moves the block to reset on the next edge.
- R10: In RUN, any of `ext_rst`, `sw_rst` or `wdt_rst` gives reset on the next edge, and takes precedence over a simultaneous standby write.
- R11: Outputs follow the state. RUN: both clocks and the oscillator on. SLEEP: CPU clock off, with peripheral clock and oscillator on. STOP: all three off. Reset and wait: both clocks off and the oscillator on. `int_rst`=1 in reset.
- R12: Both register bits read 0 whenever the state is RUN or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| ext_rst | input | 1 | External reset request, synchronous, active high |
| sw_rst | input | 1 | Software reset request |
| wdt_rst | input | 1 | Watchdog reset request |
| irq_any | input | 1 | Any interrupt request is pending |
| ext_irq | input | 1 | External interrupt pin request |
| wr_en | input | 1 | Write strobe for the standby control register |
| wr_slp | input | 1 | Sleep request bit of the write |
| wr_stp | input | 1 | Stop request bit of the write |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| int_rst | output | 1 | Internal reset to the core |
| stbc_slp | output | 1 | Stored sleep bit |
| stbc_stp | output | 1 | Stored stop bit |
| state_o | output | 3 | State: 0 reset, 1 settle wait, 2 RUN, 3 SLEEP, 4 STOP |

## Verification
The assertions check the following on every cycle:
- each single-step transition: write to SLEEP or STOP, stop priority, ignored write, SLEEP and STOP wake rules, resets out of RUN and out of the wait;
- that the wait never ends before the counter reports done;
- that the counter steps down by one;
- the clock-enable ordering and the cleared register in RUN.

Only the bench scenarios can show the things that span many cycles:
- the exact length of the wait, counted in edges, on both power-up and STOP exit;
- the reload between two consecutive waits;
- the power-up path of each build option.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [2:0] {
      PS_RESET   = 3'd0,
      PS_OSCWAIT = 3'd1,
      PS_RUN     = 3'd2,
      PS_SLEEP   = 3'd3,
      PS_STOP    = 3'd4
   } pwr_state_e;
endpackage

// File: rtl/pwr_stab_cnt.sv
module pwr_stab_cnt #(
   parameter int CNT_W  = 8,
   parameter int RELOAD = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam logic [CNT_W-1:0] RLD = CNT_W'(RELOAD);

   if (RELOAD < 1 || RELOAD >= (1 << CNT_W)) begin : g_bad_reload
      $error("pwr_stab_cnt: RELOAD must lie in 1 .. 2**CNT_W-1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= RLD;
      else if (!run_i)        cnt_q <= RLD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = run_i && (cnt_q == '0);

   // R8: each running cycle removes exactly one count
   a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R8: a fresh wait always starts from the full reload value
   a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_i) |-> (cnt_q == RLD));
endmodule

// File: rtl/pwr_stbc_reg.sv
module pwr_stbc_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_slp,
   input  logic wr_stp,
   input  logic allow_i,
   input  logic irq_i,
   input  logic clr_i,
   output logic go_sleep_o,
   output logic go_stop_o,
   output logic slp_o,
   output logic stp_o
);
   logic accept;
   logic slp_q, stp_q;

   assign accept     = wr_en && allow_i && !irq_i;
   assign go_stop_o  = accept && wr_stp;
   assign go_sleep_o = accept && wr_slp && !wr_stp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slp_q <= 1'b0;
         stp_q <= 1'b0;
      end else if (clr_i) begin
         slp_q <= 1'b0;
         stp_q <= 1'b0;
      end else if (go_stop_o) begin
         stp_q <= 1'b1;
      end else if (go_sleep_o) begin
         slp_q <= 1'b1;
      end
   end

   assign slp_o = slp_q;
   assign stp_o = stp_q;

   // R4: the stored bits never both read 1
   a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({slp_q, stp_q}));
   // R5: a write during a pending interrupt leaves the bits untouched
   a_r5_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && irq_i && !clr_i) |=> $stable({slp_q, stp_q}));
endmodule

// File: rtl/pwr_standby_ctl.sv
module pwr_standby_ctl
   import pwr_pkg::*;
#(
   parameter int HAS_POR     = 1,
   parameter int STAB_W      = 8,
   parameter int STAB_CYCLES = 5
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       ext_rst,
   input  logic       sw_rst,
   input  logic       wdt_rst,
   input  logic       irq_any,
   input  logic       ext_irq,
   input  logic       wr_en,
   input  logic       wr_slp,
   input  logic       wr_stp,
   output logic       cpu_clk_en,
   output logic       per_clk_en,
   output logic       osc_en,
   output logic       int_rst,
   output logic       stbc_slp,
   output logic       stbc_stp,
   output logic [2:0] state_o
);
   localparam pwr_state_e BOOT_ST = (HAS_POR != 0) ? PS_OSCWAIT : PS_RESET;

   if (HAS_POR != 0 && HAS_POR != 1) begin : g_bad_opt
      $error("pwr_standby_ctl: HAS_POR must be 0 or 1");
   end

   pwr_state_e st_q, st_d;
   logic       any_rst, stab_done, go_sleep, go_stop, allow, clr, pon_q;

   assign any_rst = ext_rst || sw_rst || wdt_rst;
   assign allow   = (st_q == PS_RUN) && !any_rst;
   assign clr     = (st_d == PS_RUN) || (st_d == PS_RESET);

   pwr_stab_cnt #(.CNT_W(STAB_W), .RELOAD(STAB_CYCLES)) u_cnt (
      .clk   (clk),
      .rst_n (por_n),
      .run_i (st_q == PS_OSCWAIT),
      .done_o(stab_done)
   );

   pwr_stbc_reg u_reg (
      .clk       (clk),
      .rst_n     (por_n),
      .wr_en     (wr_en),
      .wr_slp    (wr_slp),
      .wr_stp    (wr_stp),
      .allow_i   (allow),
      .irq_i     (irq_any),
      .clr_i     (clr),
      .go_sleep_o(go_sleep),
      .go_stop_o (go_stop),
      .slp_o     (stbc_slp),
      .stp_o     (stbc_stp)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PS_RESET:   if (!ext_rst) st_d = PS_RUN;
         PS_OSCWAIT: if (ext_rst) st_d = PS_RESET;
                     else if (stab_done) st_d = PS_RUN;
         PS_RUN:     if (any_rst) st_d = PS_RESET;
                     else if (go_stop) st_d = PS_STOP;
                     else if (go_sleep) st_d = PS_SLEEP;
         PS_SLEEP:   if (ext_rst) st_d = PS_RESET;
                     else if (irq_any) st_d = PS_RUN;
         PS_STOP:    if (ext_rst) st_d = PS_RESET;
                     else if (ext_irq) st_d = PS_OSCWAIT;
         default:    st_d = PS_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) st_q <= BOOT_ST;
      else        st_q <= st_d;
   end

   // power-up marker: holds reset through the first wait only
   if (HAS_POR != 0) begin : g_por
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) pon_q <= 1'b1;
         else if (st_q == PS_RUN || st_q == PS_RESET) pon_q <= 1'b0;
      end
   end else begin : g_nopor
      assign pon_q = 1'b0;
   end

   assign cpu_clk_en = (st_q == PS_RUN);
   assign per_clk_en = (st_q == PS_RUN) || (st_q == PS_SLEEP);
   assign osc_en     = (st_q != PS_STOP);
   assign int_rst    = (st_q == PS_RESET) || ((st_q == PS_OSCWAIT) && pon_q);
   assign state_o    = st_q;

   a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_RUN && wr_en && wr_slp && !wr_stp && !irq_any && !any_rst)
      |=> (st_q == PS_SLEEP && stbc_slp));
   a_r4_stop_prio: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_RUN && wr_en && wr_stp && !irq_any && !any_rst)
      |=> (st_q == PS_STOP && stbc_stp && !stbc_slp));
   a_r5_pending_run: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_RUN && wr_en && irq_any && !any_rst) |=> (st_q == PS_RUN));
   a_r6_sleep_wake: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_SLEEP && irq_any && !ext_rst) |=> (st_q == PS_RUN));
   a_r7_stop_hold: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_STOP && !ext_irq && !ext_rst) |=> (st_q == PS_STOP));
   a_r8_wait_gate: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_OSCWAIT && !stab_done && !ext_rst) |=> (st_q == PS_OSCWAIT));
   a_r9_wait_reset: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_OSCWAIT && ext_rst) |=> (st_q == PS_RESET));
   a_r10_run_reset: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_RUN && any_rst) |=> (st_q == PS_RESET));
   a_r11_clk_order: assert property (@(posedge clk) disable iff (!por_n)
      cpu_clk_en |-> (per_clk_en && osc_en));
   a_r11_stop_dark: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_STOP) |-> !(cpu_clk_en || per_clk_en || osc_en));
   a_r12_run_clear: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_RUN) |-> !(stbc_slp || stbc_stp));
endmodule

// File: tb/sim_pwr_standby_ctl.sv
`timescale 1ns/1ps
module sim_pwr_standby_ctl;
   localparam int DLY = 5;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic ext_rst = 1'b0, sw_rst = 1'b0, wdt_rst = 1'b0;
   logic irq_any = 1'b0, ext_irq = 1'b0;
   logic wr_en = 1'b0, wr_slp = 1'b0, wr_stp = 1'b0;
   logic cpu_en, per_en, osc, irst, bslp, bstp;
   logic [2:0] st;

   logic ext_rst1 = 1'b1;
   logic cpu_en1, per_en1, osc1, irst1, bslp1, bstp1;
   logic [2:0] st1;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   pwr_standby_ctl #(.HAS_POR(1), .STAB_W(4), .STAB_CYCLES(DLY)) u0 (
      .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .sw_rst(sw_rst),
      .wdt_rst(wdt_rst), .irq_any(irq_any), .ext_irq(ext_irq),
      .wr_en(wr_en), .wr_slp(wr_slp), .wr_stp(wr_stp),
      .cpu_clk_en(cpu_en), .per_clk_en(per_en), .osc_en(osc),
      .int_rst(irst), .stbc_slp(bslp), .stbc_stp(bstp), .state_o(st));

   pwr_standby_ctl #(.HAS_POR(0), .STAB_W(4), .STAB_CYCLES(DLY)) u1 (
      .clk(clk), .por_n(por_n), .ext_rst(ext_rst1), .sw_rst(1'b0),
      .wdt_rst(1'b0), .irq_any(1'b0), .ext_irq(1'b0),
      .wr_en(1'b0), .wr_slp(1'b0), .wr_stp(1'b0),
      .cpu_clk_en(cpu_en1), .per_clk_en(per_en1), .osc_en(osc1),
      .int_rst(irst1), .stbc_slp(bslp1), .stbc_stp(bstp1), .state_o(st1));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // outputs of u0 derived from the state the requirements give
   task automatic chk_state(input string tag, input int es, input int eirst);
      chk({tag, " state"}, int'(st), es);
      chk({tag, " cpu_clk_en"}, int'(cpu_en), int'(es == 2));
      chk({tag, " per_clk_en"}, int'(per_en), int'(es == 2 || es == 3));
      chk({tag, " osc_en"}, int'(osc), int'(es != 4));
      chk({tag, " int_rst"}, int'(irst), eirst);
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_to_run(input string tag);
      step(DLY);
      chk_state({tag, " still waiting"}, 1, 0);
      step(1);
      chk_state({tag, " run after wait"}, 2, 0);
      chk({tag, " bits cleared"}, int'({bslp, bstp}), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      por_n = 1'b1;
      // R1: power-up into the settle wait with reset held
      chk_state("R1 boot", 1, 1);
      // R2: no power-on option, held in reset by ext pin
      chk("R2 boot state", int'(st1), 0);
      chk("R2 boot int_rst", int'(irst1), 1);
      step(DLY);
      chk_state("R1 wait end", 1, 1);
      chk("R2 held", int'(st1), 0);
      step(1);
      chk_state("R1 run", 2, 0);
      ext_rst1 = 1'b0;
      step(1);
      chk("R2 run after release", int'(st1), 2);
      chk("R2 cpu clock", int'(cpu_en1), 1);

      // R3 R4 R5: sweep all write patterns with and without a pending irq
      for (int v = 0; v < 8; v++) begin
         automatic int es;
         automatic bit s = v[0], p = v[1], q = v[2];
         es = q ? 2 : (p ? 4 : (s ? 3 : 2));
         wr_en = 1'b1; wr_slp = s; wr_stp = p; irq_any = q;
         step(1);
         wr_en = 1'b0; wr_slp = 1'b0; wr_stp = 1'b0; irq_any = 1'b0;
         chk_state($sformatf("R3/R4/R5 write %0d", v), es, 0);
         chk($sformatf("R4/R5 bits %0d", v), int'({bslp, bstp}),
             (es == 3) ? 2 : ((es == 4) ? 1 : 0));
         if (es == 3) begin
            irq_any = 1'b1;
            step(1);
            irq_any = 1'b0;
            chk_state("R6 sleep wake", 2, 0);
            chk("R12 bits after sleep", int'({bslp, bstp}), 0);
         end else if (es == 4) begin
            irq_any = 1'b1;
            step(1);
            irq_any = 1'b0;
            chk_state("R7 irq_any ignored in stop", 4, 0);
            ext_irq = 1'b1;
            step(1);
            ext_irq = 1'b0;
            chk_state("R7 stop to wait", 1, 0);
            chk("R8 stop bit in wait", int'(bstp), 1);
            wait_to_run("R8");
         end
      end

      // R6: reset out of SLEEP
      wr_en = 1'b1; wr_slp = 1'b1;
      step(1);
      wr_en = 1'b0; wr_slp = 1'b0;
      ext_rst = 1'b1;
      step(1);
      chk_state("R6 sleep reset", 0, 1);
      chk("R12 bits in reset", int'({bslp, bstp}), 0);
      ext_rst = 1'b0;
      step(1);
      chk_state("R6 reset release", 2, 0);

      // R7: reset out of STOP
      wr_en = 1'b1; wr_stp = 1'b1;
      step(1);
      wr_en = 1'b0; wr_stp = 1'b0;
      ext_rst = 1'b1;
      step(1);
      chk_state("R7 stop reset", 0, 1);
      ext_rst = 1'b0;
      step(1);

      // R9: reset during the settle wait, then a full wait to check reload
      wr_en = 1'b1; wr_stp = 1'b1;
      step(1);
      wr_en = 1'b0; wr_stp = 1'b0;
      ext_irq = 1'b1;
      step(1);
      ext_irq = 1'b0;
      step(2);
      chk_state("R9 mid wait", 1, 0);
      ext_rst = 1'b1;
      step(1);
      ext_rst = 1'b0;
      chk_state("R9 wait reset", 0, 1);
      step(1);
      chk_state("R9 back to run", 2, 0);
      wr_en = 1'b1; wr_stp = 1'b1;
      step(1);
      wr_en = 1'b0; wr_stp = 1'b0;
      ext_irq = 1'b1;
      step(1);
      ext_irq = 1'b0;
      wait_to_run("R8 reload");

      // R10: each reset source in RUN, each racing a sleep write
      for (int k = 0; k < 3; k++) begin
         ext_rst = (k == 0); sw_rst = (k == 1); wdt_rst = (k == 2);
         wr_en = 1'b1; wr_slp = 1'b1;
         step(1);
         ext_rst = 1'b0; sw_rst = 1'b0; wdt_rst = 1'b0;
         wr_en = 1'b0; wr_slp = 1'b0;
         chk_state($sformatf("R10 source %0d", k), 0, 1);
         chk($sformatf("R10 no sleep bit %0d", k), int'(bslp), 0);
         step(1);
         chk_state($sformatf("R10 release %0d", k), 2, 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule